// File: doc/BRIEF.md
# Data Access Translation Fault Classifier

This block sits between the load/store pipeline and the data TLB. For every data access it receives the virtual address, the access size, the direction and a set of request flags (physical access, use of the alternate privilege mode, fetch of a page-table entry). It also receives the current and alternate privilege modes and the result of a TLB lookup already made for the same address. From these it forms either a physical address or one classified fault with a vector of memory-management status flags. The result is registered and appears one cycle after the request.

The checks run in a fixed order. Alignment comes first. A physical access then bypasses everything else. Next come the canonical-address check and the kernel-only superpage window. A TLB miss follows, and the per-mode read and write enables with their fault-on-read and fault-on-write bits come last. Address widths, the page size, the superpage tag window and the sign bit are parameters.

Top module: `dx_xlate_classify`

## Requirements
- R1: An access whose address has any bit set under (2^size_lg − 1) gives fault ALIGN. This beats every other condition. Its status holds only the write flag, set for writes.
- R2: The privilege mode used by all checks is `alt_mode` when `req_alt` is 1 and `cur_mode` otherwise. Mode 0 is kernel.
- R3: An aligned access with `req_phys` set gives fault NONE with `out_pa` equal to `req_va`, whatever the TLB inputs are.
- R4: If bits 63 down to 42 of the address are not all equal, the address is non-canonical. Fault is PAGE, and status has BADVA plus WR for writes.
- R5: An access with VA[47:41] = 0x7e is a superpage access. In a mode other than kernel it gives fault ACV with status ACV plus WR for writes, and the TLB is not consulted.
- R6: A kernel superpage access gives NONE. Its address is VA[40:0] with bits 43:41 copied from VA[40] and bits 63:44 zero.
- R7: A TLB miss gives fault MISS_PTE when `req_pte` is set and MISS otherwise. Status is MISS plus WR for writes.
- R8: A TLB hit that passes its permission check gives NONE with `out_pa` = {`tlb_ppn`, VA[12:0]}, zero-extended.
- R9: On a write hit, a clear `tlb_wr_en[mode]` gives ACV with status WR|ACV, plus FONW when `tlb_fonw` is set. Otherwise a set `tlb_fonw` gives PAGE with status WR|FONW.
- R10: On a read hit, a clear `tlb_rd_en[mode]` gives ACV with status ACV, plus FONR when `tlb_fonr` is set. Otherwise a set `tlb_fonr` gives PAGE with status FONR.
- R11: `out_valid` is 1 exactly one cycle after `req_valid`. Whenever the fault is not NONE, `out_pa` is 0. Fault codes are NONE=0, ALIGN=1, ACV=2, PAGE=3, MISS=4, MISS_PTE=5. Status bits are WR=0, ACV=1, FONR=2, FONW=3, BADVA=4, MISS=5. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size_lg | input | 2 | log2 of access size in bytes |
| req_write | input | 1 | 1 for a store |
| req_phys | input | 1 | Address is already physical |
| req_alt | input | 1 | Check with the alternate mode |
| req_pte | input | 1 | Access fetches a page-table entry |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | TLB lookup matched |
| tlb_ppn | input | 31 | Physical page number of the match |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Entry faults on read |
| tlb_fonw | input | 1 | Entry faults on write |
| out_valid | output | 1 | Result valid |
| out_pa | output | 64 | Physical address, 0 on a fault |
| out_fault | output | 3 | Fault code |
| out_status | output | 6 | Status flag vector |

## Verification
Several classifications can be true for one access, and the fixed priority must pick a single one. A misaligned address that is also non-canonical, a superpage or a TLB miss must still report ALIGN. A superpage access must ignore a TLB miss or disabled permissions. The sweep sets every size, direction, mode, flag and TLB pattern against addresses that are misaligned, superpage with either sign, and non-canonical. Each response is compared with the outcome of the first rule that applies, taken in requirement order.

// File: rtl/dx_pkg.sv
package dx_pkg;
   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ALIGN    = 3'd1,
      FLT_ACV      = 3'd2,
      FLT_PAGE     = 3'd3,
      FLT_MISS     = 3'd4,
      FLT_MISS_PTE = 3'd5
   } fault_e;

   localparam int ST_WR    = 0;
   localparam int ST_ACV   = 1;
   localparam int ST_FONR  = 2;
   localparam int ST_FONW  = 3;
   localparam int ST_BADVA = 4;
   localparam int ST_MISS  = 5;
   localparam int ST_W     = 6;
endpackage

// File: rtl/dx_align_chk.sv
module dx_align_chk #(
   parameter int SZ_LG_W = 2,
   localparam int NSZ    = 1 << SZ_LG_W,
   localparam int LOW_W  = NSZ - 1
) (
   input  logic [LOW_W-1:0]   va_low,
   input  logic [SZ_LG_W-1:0] size_lg,
   output logic               misaligned
);
   logic [NSZ-1:0] bad_at;

   for (genvar k = 0; k < NSZ; k++) begin : g_size
      if (k == 0) begin : g_byte
         assign bad_at[k] = 1'b0;
      end else begin : g_wide
         assign bad_at[k] = (size_lg == SZ_LG_W'(k)) && (|va_low[k-1:0]);
      end
   end

   assign misaligned = |bad_at;
endmodule

// File: rtl/dx_va_check.sv
module dx_va_check #(
   parameter int VA_W    = 64,
   parameter int VA_IMPL = 43,
   localparam int HI_W   = VA_W - VA_IMPL + 1
) (
   input  logic [HI_W-1:0] va_hi,
   output logic            canonical
);
   assign canonical = (&va_hi) || !(|va_hi);
endmodule

// File: rtl/dx_super_map.sv
module dx_super_map #(
   parameter int VA_W     = 64,
   parameter int PA_W     = 44,
   parameter int SP_HI    = 47,
   parameter int SP_LO    = 41,
   parameter int SIGN_BIT = 40,
   parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e
) (
   input  logic [SP_HI:0]    va,
   output logic              is_super,
   output logic [VA_W-1:0]   sp_pa
);
   assign is_super = (va[SP_HI:SP_LO] == SP_TAG);

   for (genvar b = 0; b < VA_W; b++) begin : g_bit
      if (b <= SIGN_BIT) begin : g_pass
         assign sp_pa[b] = va[b];
      end else if (b < PA_W) begin : g_ext
         assign sp_pa[b] = va[SIGN_BIT];
      end else begin : g_zero
         assign sp_pa[b] = 1'b0;
      end
   end
endmodule

// File: rtl/dx_perm_chk.sv
module dx_perm_chk
   import dx_pkg::*;
#(
   parameter int MODE_W = 2,
   localparam int NMODE = 1 << MODE_W
) (
   input  logic [MODE_W-1:0] mode,
   input  logic              write,
   input  logic [NMODE-1:0]  rd_en,
   input  logic [NMODE-1:0]  wr_en,
   input  logic              fonr,
   input  logic              fonw,
   output fault_e            fault,
   output logic [ST_W-1:0]   status
);
   logic rd_ok, wr_ok;
   assign rd_ok = rd_en[mode];
   assign wr_ok = wr_en[mode];

   always_comb begin
      fault  = FLT_NONE;
      status = '0;
      if (write) begin
         if (!wr_ok) begin
            fault           = FLT_ACV;
            status[ST_WR]   = 1'b1;
            status[ST_ACV]  = 1'b1;
            status[ST_FONW] = fonw;
         end else if (fonw) begin
            fault           = FLT_PAGE;
            status[ST_WR]   = 1'b1;
            status[ST_FONW] = 1'b1;
         end
      end else begin
         if (!rd_ok) begin
            fault           = FLT_ACV;
            status[ST_ACV]  = 1'b1;
            status[ST_FONR] = fonr;
         end else if (fonr) begin
            fault           = FLT_PAGE;
            status[ST_FONR] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dx_xlate_classify.sv
module dx_xlate_classify
   import dx_pkg::*;
#(
   parameter int VA_W       = 64,
   parameter int VA_IMPL    = 43,
   parameter int PA_W       = 44,
   parameter int PAGE_SHIFT = 13,
   parameter int SZ_LG_W    = 2,
   parameter int MODE_W     = 2,
   parameter int KERNEL     = 0,
   parameter int SP_HI      = 47,
   parameter int SP_LO      = 41,
   parameter int SIGN_BIT   = 40,
   parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e,
   localparam int PPN_W     = PA_W - PAGE_SHIFT,
   localparam int NMODE     = 1 << MODE_W,
   localparam int LOW_W     = (1 << SZ_LG_W) - 1,
   localparam int HI_W      = VA_W - VA_IMPL + 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_va,
   input  logic [SZ_LG_W-1:0] req_size_lg,
   input  logic               req_write,
   input  logic               req_phys,
   input  logic               req_alt,
   input  logic               req_pte,
   input  logic [MODE_W-1:0]  cur_mode,
   input  logic [MODE_W-1:0]  alt_mode,
   input  logic               tlb_hit,
   input  logic [PPN_W-1:0]   tlb_ppn,
   input  logic [NMODE-1:0]   tlb_rd_en,
   input  logic [NMODE-1:0]   tlb_wr_en,
   input  logic               tlb_fonr,
   input  logic               tlb_fonw,
   output logic               out_valid,
   output logic [VA_W-1:0]    out_pa,
   output logic [2:0]         out_fault,
   output logic [ST_W-1:0]    out_status
);
   if (PA_W > VA_W) begin : g_err_pa
      $error("PA_W must not exceed VA_W");
   end
   if (SIGN_BIT + 1 >= PA_W) begin : g_err_sign
      $error("SIGN_BIT must lie below PA_W-1");
   end
   if (SP_HI >= VA_W || SP_LO != SIGN_BIT + 1) begin : g_err_sp
      $error("superpage window must sit just above SIGN_BIT inside VA_W");
   end
   if (PAGE_SHIFT < LOW_W || PAGE_SHIFT >= PA_W) begin : g_err_page
      $error("PAGE_SHIFT out of range");
   end
   if (KERNEL >= NMODE) begin : g_err_kern
      $error("KERNEL must be a legal mode");
   end

   logic              misaligned, canonical, is_super;
   logic [VA_W-1:0]   sp_pa, hit_pa;
   logic [MODE_W-1:0] eff_mode;
   fault_e            perm_fault;
   logic [ST_W-1:0]   perm_status;

   assign eff_mode = req_alt ? alt_mode : cur_mode;

   dx_align_chk #(.SZ_LG_W(SZ_LG_W)) u_align (
      .va_low     (req_va[LOW_W-1:0]),
      .size_lg    (req_size_lg),
      .misaligned (misaligned)
   );

   dx_va_check #(.VA_W(VA_W), .VA_IMPL(VA_IMPL)) u_vachk (
      .va_hi     (req_va[VA_W-1:VA_IMPL-1]),
      .canonical (canonical)
   );

   dx_super_map #(
      .VA_W(VA_W), .PA_W(PA_W), .SP_HI(SP_HI), .SP_LO(SP_LO),
      .SIGN_BIT(SIGN_BIT), .SP_TAG(SP_TAG)
   ) u_super (
      .va       (req_va[SP_HI:0]),
      .is_super (is_super),
      .sp_pa    (sp_pa)
   );

   dx_perm_chk #(.MODE_W(MODE_W)) u_perm (
      .mode   (eff_mode),
      .write  (req_write),
      .rd_en  (tlb_rd_en),
      .wr_en  (tlb_wr_en),
      .fonr   (tlb_fonr),
      .fonw   (tlb_fonw),
      .fault  (perm_fault),
      .status (perm_status)
   );

   always_comb begin
      hit_pa           = '0;
      hit_pa[PA_W-1:0] = {tlb_ppn, req_va[PAGE_SHIFT-1:0]};
   end

   fault_e          nx_fault;
   logic [ST_W-1:0] nx_status;
   logic [VA_W-1:0] nx_pa;

   always_comb begin
      nx_fault  = FLT_NONE;
      nx_status = '0;
      nx_pa     = '0;
      if (misaligned) begin
         nx_fault         = FLT_ALIGN;
         nx_status[ST_WR] = req_write;
      end else if (req_phys) begin
         nx_pa = req_va;
      end else if (!canonical) begin
         nx_fault            = FLT_PAGE;
         nx_status[ST_BADVA] = 1'b1;
         nx_status[ST_WR]    = req_write;
      end else if (is_super) begin
         if (eff_mode != MODE_W'(KERNEL)) begin
            nx_fault          = FLT_ACV;
            nx_status[ST_ACV] = 1'b1;
            nx_status[ST_WR]  = req_write;
         end else begin
            nx_pa = sp_pa;
         end
      end else if (!tlb_hit) begin
         nx_fault           = req_pte ? FLT_MISS_PTE : FLT_MISS;
         nx_status[ST_MISS] = 1'b1;
         nx_status[ST_WR]   = req_write;
      end else begin
         nx_fault  = perm_fault;
         nx_status = perm_status;
         if (perm_fault == FLT_NONE) nx_pa = hit_pa;
      end
   end

   fault_e fault_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_pa     <= '0;
         fault_q    <= FLT_NONE;
         out_status <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_pa     <= nx_pa;
            fault_q    <= nx_fault;
            out_status <= nx_status;
         end
      end
   end

   assign out_fault = fault_q;
endmodule

// File: rtl/dx_xlate_chk.sv
module dx_xlate_chk #(
   parameter int VA_W    = 64,
   parameter int SZ_LG_W = 2,
   parameter int MODE_W  = 2,
   parameter int ST_W    = 6
) (
   input logic               clk,
   input logic               rst,
   input logic               req_valid,
   input logic [VA_W-1:0]    req_va,
   input logic [SZ_LG_W-1:0] req_size_lg,
   input logic               req_write,
   input logic               req_phys,
   input logic               req_alt,
   input logic [MODE_W-1:0]  cur_mode,
   input logic [MODE_W-1:0]  alt_mode,
   input logic               out_valid,
   input logic [VA_W-1:0]    out_pa,
   input logic [2:0]         out_fault,
   input logic [ST_W-1:0]    out_status
);
   logic bad_align, canon, sp_hit, user_mode;
   assign bad_align = |(req_va[3:0] & ((4'd1 << req_size_lg) - 4'd1));
   assign canon     = (&req_va[63:42]) || !(|req_va[63:42]);
   assign sp_hit    = (req_va[47:41] == 7'h7e);
   assign user_mode = (req_alt ? alt_mode : cur_mode) != '0;

   a_r1_align_first: assert property (@(posedge clk) disable iff (rst)
      req_valid && bad_align |=> out_fault == 3'd1 && out_status == ST_W'($past(req_write)));

   a_r3_phys_bypass: assert property (@(posedge clk) disable iff (rst)
      req_valid && !bad_align && req_phys |=> out_fault == 3'd0 && out_pa == $past(req_va));

   a_r5_super_user: assert property (@(posedge clk) disable iff (rst)
      req_valid && !bad_align && !req_phys && canon && sp_hit && user_mode
      |=> out_fault == 3'd2 && out_status[1]);

   a_r7_miss_flag: assert property (@(posedge clk) disable iff (rst)
      out_valid && (out_fault == 3'd4 || out_fault == 3'd5) |-> out_status[5]);

   a_r11_valid_rise: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> out_valid);

   a_r11_valid_fall: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !out_valid);

   a_r11_pa_zero: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_fault != 3'd0 |-> out_pa == '0);
endmodule

bind dx_xlate_classify dx_xlate_chk #(
   .VA_W(VA_W), .SZ_LG_W(SZ_LG_W), .MODE_W(MODE_W), .ST_W(dx_pkg::ST_W)
) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
   .req_size_lg(req_size_lg), .req_write(req_write), .req_phys(req_phys),
   .req_alt(req_alt), .cur_mode(cur_mode), .alt_mode(alt_mode),
   .out_valid(out_valid), .out_pa(out_pa), .out_fault(out_fault),
   .out_status(out_status)
);

// File: tb/sim_dx_xlate_classify.sv
module sim_dx_xlate_classify;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [63:0] req_va = '0;
   logic [1:0]  req_size_lg = '0;
   logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_pte = 1'b0;
   logic [1:0]  cur_mode = '0, alt_mode = '0;
   logic        tlb_hit = 1'b0;
   logic [30:0] tlb_ppn = '0;
   logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
   logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
   logic        out_valid;
   logic [63:0] out_pa;
   logic [2:0]  out_fault;
   logic [5:0]  out_status;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dx_xlate_classify u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
      .req_size_lg(req_size_lg), .req_write(req_write), .req_phys(req_phys),
      .req_alt(req_alt), .req_pte(req_pte), .cur_mode(cur_mode),
      .alt_mode(alt_mode), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
      .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr),
      .tlb_fonw(tlb_fonw), .out_valid(out_valid), .out_pa(out_pa),
      .out_fault(out_fault), .out_status(out_status)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference outcome, taken rule by rule in requirement order.
   task automatic model(output logic [2:0] f, output logic [5:0] s,
                        output logic [63:0] pa, output string req);
      logic [1:0]  m;
      logic [63:0] sz;
      m  = req_alt ? alt_mode : cur_mode;                       // R2
      sz = 64'd1 << req_size_lg;
      f = 3'd0; s = '0; pa = '0;
      if ((req_va & (sz - 64'd1)) != 0) begin
         f = 3'd1; s = {5'b0, req_write}; req = "R1";
      end else if (req_phys) begin
         pa = req_va; req = "R3";
      end else if (!(req_va[63:42] == '0 || req_va[63:42] == '1)) begin
         f = 3'd3; s = 6'b010000 | {5'b0, req_write}; req = "R4";
      end else if (req_va[47:41] == 7'h7e) begin
         if (m != 2'd0) begin
            f = 3'd2; s = 6'b000010 | {5'b0, req_write}; req = "R5";
         end else begin
            pa = req_va & 64'hFFF_FFFF_FFFF;
            if (req_va[40]) pa = pa | 64'hF00_0000_0000;
            else            pa = pa & 64'hFF_FFFF_FFFF;
            req = "R6";
         end
      end else if (!tlb_hit) begin
         f = req_pte ? 3'd5 : 3'd4; s = 6'b100000 | {5'b0, req_write}; req = "R7";
      end else if (req_write) begin
         req = "R9";
         if (!tlb_wr_en[m]) begin f = 3'd2; s = 6'b000011 | (tlb_fonw ? 6'b001000 : 6'b0); end
         else if (tlb_fonw) begin f = 3'd3; s = 6'b001001; end
      end else begin
         req = "R10";
         if (!tlb_rd_en[m]) begin f = 3'd2; s = 6'b000010 | (tlb_fonr ? 6'b000100 : 6'b0); end
         else if (tlb_fonr) begin f = 3'd3; s = 6'b000100; end
      end
      if (f == 3'd0 && tlb_hit && req == "R9")  req = "R8";
      if (f == 3'd0 && tlb_hit && req == "R10") req = "R8";
      if (f == 3'd0 && req != "R3" && req != "R6" && req != "R8")
         pa = (64'(tlb_ppn) << 13) + (req_va & 64'h1FFF);
      if (f == 3'd0 && req == "R8")
         pa = (64'(tlb_ppn) << 13) + (req_va & 64'h1FFF);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] vas [7];
      logic [2:0]  ef;
      logic [5:0]  es;
      logic [63:0] ep;
      string       rq;
      vas[0] = 64'h0000_0000_0012_3458;
      vas[1] = 64'h0000_0000_0012_3459;
      vas[2] = 64'h0000_0000_0012_345A;
      vas[3] = 64'h0000_0000_0012_345C;
      vas[4] = 64'hFFFF_FD00_0000_1238;   // superpage, bit 40 set
      vas[5] = 64'hFFFF_FC00_0000_1238;   // superpage, bit 40 clear
      vas[6] = 64'h0001_0000_0000_1238;   // non-canonical
      tlb_ppn = 31'h5A5A5;

      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 reset valid", 64'(out_valid), 64'd0);
      check("R11 reset fault", 64'(out_fault), 64'd0);
      check("R11 reset status", 64'(out_status), 64'd0);
      check("R11 reset pa", out_pa, 64'd0);
      rst = 1'b0;

      for (int v = 0; v < 7; v++)
      for (int sz = 0; sz < 4; sz++)
      for (int wr = 0; wr < 2; wr++)
      for (int ph = 0; ph < 2; ph++)
      for (int al = 0; al < 2; al++)
      for (int md = 0; md < 4; md++)
      for (int ht = 0; ht < 2; ht++)
      for (int fn = 0; fn < 4; fn++)
      for (int pm = 0; pm < 4; pm++) begin
         req_valid   = 1'b1;
         req_va      = vas[v];
         req_size_lg = 2'(sz);
         req_write   = wr[0];
         req_phys    = ph[0];
         req_alt     = al[0];
         cur_mode    = 2'(md);
         alt_mode    = 2'(3 - md);
         tlb_hit     = ht[0];
         tlb_fonr    = fn[0];
         tlb_fonw    = fn[1];
         req_pte     = pm[0];
         tlb_rd_en   = pm[1] ? 4'b1010 : 4'b0101;
         tlb_wr_en   = pm[1] ? 4'b0110 : 4'b1001;
         model(ef, es, ep, rq);
         @(negedge clk);
         check({rq, " valid"},  64'(out_valid), 64'd1);
         check({rq, " fault"},  64'(out_fault), 64'(ef));
         check({rq, " status"}, 64'(out_status), 64'(es));
         check({rq, " pa"},     out_pa, ep);
      end

      // R11: no request, no result
      req_valid = 1'b0;
      @(negedge clk);
      check("R11 idle valid", 64'(out_valid), 64'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule